// File: doc/BRIEF.md
# UART Status Flag Controller

This block holds the seven status flags of a serial communications interface and the logic that sets and clears them. The flags say whether the transmit data register is empty, whether transmission has completed, whether a received byte is waiting, and whether an idle line, overrun, noise or framing error has been seen. The transmitter and receiver datapaths report their events to the block as single-cycle pulses. A CPU register bus reads the flags through one status byte and gives three strobes: status read, data read and data write.

A flag never clears on a single access. A status read that sees the flag set arms it. The next data access of the matching kind then clears it. Transmit-side flags clear on a data write and receive-side flags clear on a data read. A flag that becomes set after the status read is not armed, so a byte that arrives between the read and the data access is not lost. The block also drives one registered interrupt request, built from the flags and four enable inputs.

Top module: `uart_status_ctrl`

## Requirements
- R1: Status byte layout from bit 7 down to bit 1 is TDRE, TC, RDRF, IDLE, OR, NF, FE, and bit 0 always reads 0. Synchronous reset gives a status byte of 8'hC0 and an irq of 0.
- R2: TDRE sets in the cycle after a `tx_load` pulse. It clears only on a `data_wr` that follows a `stat_rd` taken while TDRE was set.
- R3: On a `tx_done` pulse, TC sets if `tx_en` is 1, TDRE is 1 and `tx_pending` is 0, or if `tx_en` is 0. A `tx_done` with `tx_en`=1 and either TDRE=0 or `tx_pending`=1 leaves TC unchanged.
- R4: TC clears only on a `data_wr` that follows a `stat_rd` taken while TC was set.
- R5: RDRF sets on an `rx_load` pulse. It clears only on a `data_rd` that follows a `stat_rd` taken while RDRF was set.
- R6: IDLE, OR, NF and FE set on `rx_idle`, `rx_overrun`, `rx_noise` and `rx_frame` respectively. Each clears through the same status-read-then-data-read sequence as RDRF. A `data_wr` does not clear them, and a `data_rd` does not clear TDRE or TC.
- R7: When `rx_load`, `rx_noise` and `rx_frame` pulse in the same cycle, RDRF, NF and FE all become set after that same clock edge.
- R8: A flag that was clear at the time of a status read is not cleared by the data access that follows. A data access consumes the arming, so a second data access without a new status read clears nothing.
- R9: When a set event and a qualifying clear access fall in the same cycle, the flag stays set.
- R10: `irq` is registered one cycle behind the flags. It is the OR of TDRE&`ie_tdre`, TC&`ie_tc`, (RDRF|OR)&`ie_rx` and IDLE&`ie_idle`. NF and FE never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_rd | input | 1 | CPU status register read strobe |
| data_rd | input | 1 | CPU data register read strobe |
| data_wr | input | 1 | CPU data register write strobe |
| tx_load | input | 1 | Data register moved into the transmit shifter |
| tx_done | input | 1 | End of a transmitted frame, preamble or break |
| tx_en | input | 1 | Transmitter enabled |
| tx_pending | input | 1 | Further data, preamble or break queued |
| rx_load | input | 1 | Receive shifter moved into the data register |
| rx_idle | input | 1 | Idle line detected |
| rx_overrun | input | 1 | Receive overrun detected |
| rx_noise | input | 1 | Noise detected on the received word |
| rx_frame | input | 1 | Framing error on the received word |
| ie_tdre | input | 1 | Interrupt enable for TDRE |
| ie_tc | input | 1 | Interrupt enable for TC |
| ie_rx | input | 1 | Interrupt enable for RDRF and OR |
| ie_idle | input | 1 | Interrupt enable for IDLE |
| stat_q | output | STAT_W | Status byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default STAT_W of 8. At that width the seven flags and the constant zero bit 0 fill the whole status byte, so each check compares all eight bits against one literal. The vector table runs arming, the consumption of an arm, a set and a clear in the same cycle, and both TC set conditions in a single continuous sequence. Directed tests then cover the reset value and the one-cycle latency of the interrupt for enabled and non-enabled flags.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int FLAG_N  = 7;
  localparam int FL_TDRE = 6;
  localparam int FL_TC   = 5;
  localparam int FL_RDRF = 4;
  localparam int FL_IDLE = 3;
  localparam int FL_OR   = 2;
  localparam int FL_NF   = 1;
  localparam int FL_FE   = 0;
  // Reset value per flag: TDRE and TC come up set.
  localparam logic [FLAG_N-1:0] FLAG_RST    = 7'b1100000;
  // Flags cleared by a data write (others are cleared by a data read).
  localparam logic [FLAG_N-1:0] FLAG_WR_CLR = 7'b1100000;
endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
  parameter logic RST_VAL = 1'b0,
  parameter logic CLR_WR  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic data_wr,
  input  logic set_ev,
  output logic flag_q
);
  logic arm_q;
  logic acc;

  generate
    if (CLR_WR) begin : g_wr
      assign acc = data_wr;
    end else begin : g_rd
      assign acc = data_rd;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      if (set_ev)
        flag_q <= 1'b1;
      else if (acc && arm_q)
        flag_q <= 1'b0;
      if (acc)
        arm_q <= 1'b0;
      else if (stat_rd && flag_q)
        arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_flag_events.sv
module uart_flag_events
  import uart_stat_pkg::*;
(
  input  logic              tx_load,
  input  logic              tx_done,
  input  logic              tx_en,
  input  logic              tx_pending,
  input  logic              tdre_now,
  input  logic              rx_load,
  input  logic              rx_idle,
  input  logic              rx_overrun,
  input  logic              rx_noise,
  input  logic              rx_frame,
  output logic [FLAG_N-1:0] set_vec
);
  logic tc_hit;

  always_comb begin
    tc_hit = tx_done && ((tx_en && tdre_now && !tx_pending) || !tx_en);
    set_vec          = '0;
    set_vec[FL_TDRE] = tx_load;
    set_vec[FL_TC]   = tc_hit;
    set_vec[FL_RDRF] = rx_load;
    set_vec[FL_IDLE] = rx_idle;
    set_vec[FL_OR]   = rx_overrun;
    set_vec[FL_NF]   = rx_noise;
    set_vec[FL_FE]   = rx_frame;
  end
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge
  import uart_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_N-1:0] flags,
  input  logic              ie_tdre,
  input  logic              ie_tc,
  input  logic              ie_rx,
  input  logic              ie_idle,
  output logic              irq
);
  logic req;

  always_comb begin
    req = (flags[FL_TDRE] && ie_tdre)
        | (flags[FL_TC] && ie_tc)
        | ((flags[FL_RDRF] || flags[FL_OR]) && ie_rx)
        | (flags[FL_IDLE] && ie_idle);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= req;
  end
endmodule

// File: rtl/uart_status_ctrl.sv
module uart_status_ctrl
  import uart_stat_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              tx_load,
  input  logic              tx_done,
  input  logic              tx_en,
  input  logic              tx_pending,
  input  logic              rx_load,
  input  logic              rx_idle,
  input  logic              rx_overrun,
  input  logic              rx_noise,
  input  logic              rx_frame,
  input  logic              ie_tdre,
  input  logic              ie_tc,
  input  logic              ie_rx,
  input  logic              ie_idle,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  localparam int PAD_W = STAT_W - FLAG_N;

  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] set_vec;

  uart_flag_events u_ev (
    .tx_load    (tx_load),
    .tx_done    (tx_done),
    .tx_en      (tx_en),
    .tx_pending (tx_pending),
    .tdre_now   (flags[FL_TDRE]),
    .rx_load    (rx_load),
    .rx_idle    (rx_idle),
    .rx_overrun (rx_overrun),
    .rx_noise   (rx_noise),
    .rx_frame   (rx_frame),
    .set_vec    (set_vec)
  );

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    uart_flag_cell #(
      .RST_VAL (FLAG_RST[i]),
      .CLR_WR  (FLAG_WR_CLR[i])
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .stat_rd (stat_rd),
      .data_rd (data_rd),
      .data_wr (data_wr),
      .set_ev  (set_vec[i]),
      .flag_q  (flags[i])
    );
  end

  uart_irq_merge u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags   (flags),
    .ie_tdre (ie_tdre),
    .ie_tc   (ie_tc),
    .ie_rx   (ie_rx),
    .ie_idle (ie_idle),
    .irq     (irq)
  );

  assign stat_q = {flags, {PAD_W{1'b0}}};
endmodule

// File: rtl/uart_status_ctrl_chk.sv
module uart_status_ctrl_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stat_rd,
  input logic              data_rd,
  input logic              data_wr,
  input logic              tx_load,
  input logic              tx_done,
  input logic              tx_en,
  input logic              tx_pending,
  input logic              rx_load,
  input logic              rx_idle,
  input logic              rx_overrun,
  input logic              rx_noise,
  input logic              rx_frame,
  input logic              ie_tdre,
  input logic              ie_tc,
  input logic              ie_rx,
  input logic              ie_idle,
  input logic [STAT_W-1:0] stat_q,
  input logic              irq
);
  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> (stat_q[7:0] == 8'hC0 && !irq));

  assert_pad_zero_R1: assert property (@(posedge clk) disable iff (rst)
    stat_q[0] == 1'b0);

  assert_tdre_set_R2: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> stat_q[7]);

  assert_tdre_clear_on_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(stat_q[7])) |-> $past(data_wr));

  assert_tc_clear_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(stat_q[6])) |-> $past(data_wr));

  assert_rdrf_clear_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(stat_q[5])) |-> $past(data_rd));

  assert_err_same_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_load && rx_noise && rx_frame) |=> (stat_q[5] && stat_q[2] && stat_q[1]));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    rx_load |=> stat_q[5]);

  assert_irq_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (ie_idle && stat_q[4]) |=> irq);
endmodule

bind uart_status_ctrl uart_status_ctrl_chk #(.STAT_W(STAT_W)) u_chk (.*);

// File: tb/uart_status_ctrl_tb.sv
module uart_status_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stat_rd = 0, data_rd = 0, data_wr = 0;
  logic tx_load = 0, tx_done = 0, tx_en = 0, tx_pending = 0;
  logic rx_load = 0, rx_idle = 0, rx_overrun = 0, rx_noise = 0, rx_frame = 0;
  logic ie_tdre = 0, ie_tc = 0, ie_rx = 0, ie_idle = 0;
  logic [7:0] stat_q;
  logic irq;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_status_ctrl u_dut (.*);

  // Inputs: {stat_rd,data_rd,data_wr,tx_load,tx_done,tx_en,tx_pending,
  //          rx_load,rx_idle,rx_overrun,rx_noise,rx_frame}, expected status.
  localparam int NV = 26;
  localparam logic [19:0] VEC [0:NV-1] = '{
    {12'b100000000000, 8'hC0}, // arm TDRE, TC (R8)
    {12'b001000000000, 8'h00}, // write clears TDRE R2 and TC R4
    {12'b000000010011, 8'h26}, // RDRF, NF, FE together R7
    {12'b010000000000, 8'h26}, // read without status read: no clear R5
    {12'b100000000000, 8'h26}, // arm RDRF, NF, FE
    {12'b000000001000, 8'h36}, // IDLE after arm R6
    {12'b010000000000, 8'h10}, // read clears armed only R8
    {12'b000100000000, 8'h90}, // tx_load sets TDRE R2
    {12'b000011000000, 8'hD0}, // TC: enabled, TDRE, none pending R3
    {12'b100000000000, 8'hD0}, // arm TDRE, TC, IDLE
    {12'b001100000000, 8'h90}, // write + tx_load: set wins R9, TC clears R4
    {12'b001000000000, 8'h90}, // arm consumed R8
    {12'b100000000000, 8'h90}, // arm TDRE, IDLE
    {12'b010000000000, 8'h80}, // read clears IDLE only R6
    {12'b001000000000, 8'h00}, // write clears TDRE R2
    {12'b000011000000, 8'h00}, // TC blocked: TDRE clear R3
    {12'b000010000000, 8'h40}, // TC: transmitter disabled R3
    {12'b100000000000, 8'h40}, // arm TC
    {12'b001000000000, 8'h00}, // TC cleared R4
    {12'b000100000000, 8'h80}, // TDRE set
    {12'b000011100000, 8'h80}, // TC blocked: pending R3
    {12'b000011000000, 8'hC0}, // TC set R3
    {12'b000000000100, 8'hC8}, // OR set R6
    {12'b100000000000, 8'hC8}, // arm TDRE, TC, OR
    {12'b010000000100, 8'hC8}, // read + overrun: set wins R9
    {12'b010000000000, 8'hC8}  // OR arm consumed R8
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] v);
    {stat_rd, data_rd, data_wr, tx_load, tx_done, tx_en, tx_pending,
     rx_load, rx_idle, rx_overrun, rx_noise, rx_frame} = v;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    drive(12'b0);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset status", stat_q, 8'hC0);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:8]);
      tick();
      chk($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8 R9)", i), stat_q, VEC[i][7:0]);
    end

    // R10: enabled rx group sees OR set; irq one cycle later
    ie_rx = 1'b1;
    tick();
    chk("R10 irq from OR", {7'b0, irq}, 8'h01);
    ie_rx = 1'b0;
    tick();
    chk("R10 irq drops when disabled", {7'b0, irq}, 8'h00);

    // R1 again: reset from a busy state, then irq latency
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 re-reset status", stat_q, 8'hC0);
    ie_idle = 1'b1;
    drive(12'b000000001000);
    tick();
    chk("R10 IDLE set", stat_q, 8'hD0);
    chk("R10 irq not yet", {7'b0, irq}, 8'h00);
    tick();
    chk("R10 irq after one cycle", {7'b0, irq}, 8'h01);
    ie_idle = 1'b0;

    // R10: NF and FE never raise irq
    rst = 1'b1;
    tick();
    rst = 1'b0;
    ie_rx = 1'b1;
    drive(12'b000000000011);
    tick();
    tick();
    chk("R10 NF FE set", stat_q, 8'hC6);
    chk("R10 no irq from NF FE", {7'b0, irq}, 8'h00);

    // R2: TDRE drives irq when enabled
    ie_tdre = 1'b1;
    tick();
    chk("R10 irq from TDRE", {7'b0, irq}, 8'h01);
    ie_tdre = 1'b0;
    ie_rx = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule